// File: doc/BRIEF.md
# Block-Compressed ADPCM Sample Decoder

This block sits between a byte-wide sample FIFO and an audio output stage. Each time the output stage raises its sample strobe, the decoder produces one unsigned 8-bit sample in offset-binary form. A control byte picks one of two modes. In pass-through mode each strobe takes one FIFO byte and forwards it unchanged. In compressed mode the FIFO carries 15-byte packets. Each packet holds a flags byte and then 14 data bytes, and those data bytes expand to 28 samples.

For every compressed sample, the decoder takes a 4-bit nibble and places it at the top of a signed 16-bit word. It shifts that word right arithmetically by the packet's shift amount. It then adds a two-tap prediction built from the two previous decoded values and one of sixteen programmable signed coefficient pairs. The sum is clamped to 16 bits. It is scaled down to 8 bits with truncation toward zero and converted to offset binary. When the FIFO has no byte at a point where one is needed, the decoder emits the silence code 0x80 and keeps its place in the packet.

The coefficient pairs live in a small register file that the host writes. A FIFO flush input sends the decoder back to the start of a packet.

Top module: `adpcm_blk_decoder`

## Requirements
- R1: The mode is chosen from `mode_ctrl` AND 0x83. A result of 0x82 selects compressed decoding. Any other value, including 0x80, 0x83 and 0x03, selects pass-through.
- R2: In pass-through mode, a strobe with a byte available pops exactly one byte, and that byte appears on `sample_out` with `out_valid` one cycle later. With the FIFO empty, the output is 0x80 one cycle later and nothing is popped.
- R3: The first strobe of a packet pops the flags byte. In the next cycle the decoder pops the first data byte, and the sample appears two cycles after the strobe. Flags bits 3:0 are the shift amount and bits 7:4 are the filter index. Every other compressed sample appears one cycle after its strobe.
- R4: Sample 0, 2, 4, … of a packet pops a new data byte and decodes its low nibble. The following odd sample decodes the high nibble of that same byte without popping.
- R5: The prediction is ((p1·f0 + p2·f1 + 32) >> 6), computed with 32-bit signed arithmetic. For filter index k, f0 is the signed byte at coefficient address 2k+1 and f1 is the signed byte at address 2k. Coefficients reset to zero.
- R6: The shifted nibble value plus the prediction saturates to the range −32768..32767.
- R7: The output byte is the saturated value divided by 256, truncated toward zero, then XORed with 0x80. So −256 gives 0x7F and −128 gives 0x80.
- R8: After each decoded sample, p2 takes the old p1 and p1 takes the new saturated value. Both reset to zero. Both persist across packet boundaries and across flushes.
- R9: After the 28th sample of a packet, the next compressed strobe expects a new flags byte.
- R10: When a byte is needed and the FIFO is empty, the output is 0x80 and nothing is popped. A flags byte that has already been taken is kept, and the next strobe retries the data byte.
- R11: `fifo_flush` returns the decoder to the packet-start state and cancels any pending header fetch. A strobe in the same cycle as a flush is dropped.
- R12: After reset, `out_valid` and `fifo_pop` are low and `sample_out` is 0x80. Each accepted strobe gives exactly one `out_valid` pulse. Strobes must be at least three cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_ctrl | input | 8 | Channel control byte (mode selection, R1) |
| coef_we | input | 1 | Coefficient register write enable |
| coef_addr | input | 5 | Coefficient byte address (2k = f1, 2k+1 = f0) |
| coef_wdata | input | 8 | Signed coefficient byte to write |
| fifo_flush | input | 1 | FIFO reset; forces the packet-start state |
| fifo_empty | input | 1 | FIFO has no byte available |
| fifo_rdata | input | 8 | Head byte of the FIFO (show-ahead) |
| fifo_pop | output | 1 | Consume the head byte at this clock edge |
| sample_req | input | 1 | Sample strobe, one cycle wide |
| out_valid | output | 1 | Pulse: `sample_out` holds a new sample |
| sample_out | output | 8 | Offset-binary 8-bit output sample |

## Verification
Every result is registered. A pass-through sample, a mid-packet compressed sample and a silence code due to underrun all appear one cycle after the strobe. The first sample of a packet appears two cycles after its strobe, because the flags byte and the first data byte are popped on consecutive edges. The bench raises each strobe on a falling edge and then counts falling edges until `out_valid` is seen. It checks both that count against the expected 1 or 2 and the sampled value. After every sample it also compares the FIFO read position with the position its own model predicts, so an extra or missing pop is reported even when the output value happens to match.

// File: rtl/adpcm_dec_pkg.sv
// Package: shared constants and types for the block-compressed ADPCM decoder.
// Assumes 8-bit FIFO bytes and 16-bit signed decoded samples.
package adpcm_dec_pkg;
    localparam int BYTE_W   = 8;
    localparam int SAMP_W   = 16;
    localparam int ACC_W    = 32;
    localparam int PRED_SH  = 6;
    localparam int ROUND_K  = 32;

    localparam logic [BYTE_W-1:0] CTRL_MASK   = 8'h83;
    localparam logic [BYTE_W-1:0] CTRL_PACKED = 8'h82;
    localparam logic [BYTE_W-1:0] SILENCE     = 8'h80;

    // Flags byte of a packet: filter index in the upper nibble, shift in the lower.
    typedef struct packed {
        logic [3:0] filt;
        logic [3:0] shamt;
    } pkt_flags_t;
endpackage

// File: rtl/adpcm_coef_rf.sv
// Module: coefficient register file holding NUM_FILT signed byte pairs.
// Byte 2k is the second tap (f1) of filter k and byte 2k+1 is the first tap (f0).
// Assumes NUM_FILT is a power of two, at least 2. All bytes reset to zero.
module adpcm_coef_rf #(
    parameter int NUM_FILT = 16,
    parameter int FILT_W   = $clog2(NUM_FILT),
    parameter int AW       = FILT_W + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [AW-1:0]         waddr,
    input  logic [7:0]            wdata,
    input  logic [FILT_W-1:0]     sel,
    output logic signed [7:0]     tap0,
    output logic signed [7:0]     tap1
);
    localparam int DEPTH = 2 * NUM_FILT;

    logic [7:0] regs_q [DEPTH];

    // Host write port with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) regs_q[i] <= 8'h00;
        end else if (we) begin
            regs_q[waddr] <= wdata;
        end
    end

    // Pair read for the selected filter.
    always_comb begin
        tap0 = $signed(regs_q[{sel, 1'b1}]);
        tap1 = $signed(regs_q[{sel, 1'b0}]);
    end
endmodule

// File: rtl/adpcm_predictor.sv
// Module: combinational two-tap predictor, saturator and 8-bit offset-binary converter.
// Assumes history values are the previous two saturated 16-bit results.
module adpcm_predictor
    import adpcm_dec_pkg::*;
(
    input  logic [3:0]               nib,
    input  logic [3:0]               shamt,
    input  logic signed [7:0]        tap0,
    input  logic signed [7:0]        tap1,
    input  logic signed [SAMP_W-1:0] hist1,
    input  logic signed [SAMP_W-1:0] hist2,
    output logic signed [SAMP_W-1:0] sat_val,
    output logic [BYTE_W-1:0]        code
);
    localparam logic signed [ACC_W-1:0] POS_LIM = ACC_W'(32767);
    localparam logic signed [ACC_W-1:0] NEG_LIM = -ACC_W'(32768);

    logic signed [SAMP_W-1:0] nib_word;
    logic signed [SAMP_W-1:0] nib_shifted;
    logic signed [ACC_W-1:0]  h1x, h2x, t0x, t1x, acc, pred, total;
    logic signed [7:0]        quot;

    // Nibble placement and per-packet scaling.
    always_comb begin
        nib_word    = $signed({nib, 12'h000});
        nib_shifted = nib_word >>> shamt;
    end

    // Two-tap multiply-accumulate with rounding, in 32-bit signed arithmetic.
    always_comb begin
        h1x   = {{(ACC_W-SAMP_W){hist1[SAMP_W-1]}}, hist1};
        h2x   = {{(ACC_W-SAMP_W){hist2[SAMP_W-1]}}, hist2};
        t0x   = {{(ACC_W-8){tap0[7]}}, tap0};
        t1x   = {{(ACC_W-8){tap1[7]}}, tap1};
        acc   = h1x * t0x + h2x * t1x + ACC_W'(ROUND_K);
        pred  = acc >>> PRED_SH;
        total = {{(ACC_W-SAMP_W){nib_shifted[SAMP_W-1]}}, nib_shifted} + pred;
    end

    // Clamp to the 16-bit signed range.
    always_comb begin
        if (total > POS_LIM)      sat_val = 16'sh7FFF;
        else if (total < NEG_LIM) sat_val = 16'sh8000;
        else                      sat_val = total[SAMP_W-1:0];
    end

    // Divide by 256 toward zero, then flip the sign bit for offset binary.
    always_comb begin
        quot = sat_val[15:8];
        if (sat_val[15] && (sat_val[7:0] != 8'h00)) quot = quot + 8'sd1;
        code = quot ^ SILENCE;
    end
endmodule

// File: rtl/adpcm_seq.sv
// Module: packet sequencer. Handles mode choice, flags capture, nibble order, FIFO pops,
// underrun silence, prediction history and the output register.
// Assumes a show-ahead FIFO (fifo_rdata valid whenever fifo_empty is low) and
// strobes at least three cycles apart. A strobe during a pending header fetch is ignored.
module adpcm_seq
    import adpcm_dec_pkg::*;
#(
    parameter int PKT_SAMPLES = 28,
    parameter int FILT_W      = 4,
    parameter int IDX_W       = $clog2(PKT_SAMPLES)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [BYTE_W-1:0]        mode_ctrl,
    input  logic                     sample_req,
    input  logic                     fifo_flush,
    input  logic                     fifo_empty,
    input  logic [BYTE_W-1:0]        fifo_rdata,
    output logic                     fifo_pop,
    output logic [3:0]               nib,
    output logic [3:0]               shamt,
    output logic [FILT_W-1:0]        filt_sel,
    output logic signed [SAMP_W-1:0] hist1,
    output logic signed [SAMP_W-1:0] hist2,
    input  logic signed [SAMP_W-1:0] sat_val,
    input  logic [BYTE_W-1:0]        code,
    output logic                     out_valid,
    output logic [BYTE_W-1:0]        sample_out,
    output logic                     hdr_valid,
    output logic                     pend,
    output logic [IDX_W-1:0]         idx
);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(PKT_SAMPLES - 1);

    pkt_flags_t         flags_q, flags_n;
    logic [BYTE_W-1:0]  byte_q, byte_n;
    logic [IDX_W-1:0]   idx_q, idx_n;
    logic               hdr_q, hdr_n, pend_q, pend_n;
    logic               packed_mode, emit, use_dec, adv;
    logic [BYTE_W-1:0]  out_n;

    // Mode decode from the control byte.
    assign packed_mode = ((mode_ctrl & CTRL_MASK) == CTRL_PACKED);

    // Nibble source: a fresh byte for even positions, the held byte's top half for odd ones.
    assign nib      = idx_q[0] ? byte_q[7:4] : fifo_rdata[3:0];
    assign shamt    = flags_q.shamt;
    assign filt_sel = flags_q.filt[FILT_W-1:0];

    // Next-state and pop decision for one cycle.
    always_comb begin
        fifo_pop = 1'b0;
        emit     = 1'b0;
        use_dec  = 1'b0;
        adv      = 1'b0;
        hdr_n    = hdr_q;
        pend_n   = pend_q;
        idx_n    = idx_q;
        flags_n  = flags_q;
        byte_n   = byte_q;
        if (fifo_flush) begin
            hdr_n  = 1'b0;
            pend_n = 1'b0;
            idx_n  = '0;
        end else if (!packed_mode) begin
            pend_n = 1'b0;
            if (sample_req) begin
                emit     = 1'b1;
                fifo_pop = !fifo_empty;
            end
        end else if (pend_q) begin
            pend_n = 1'b0;
            emit   = 1'b1;
            if (!fifo_empty) begin
                fifo_pop = 1'b1;
                use_dec  = 1'b1;
                byte_n   = fifo_rdata;
                adv      = 1'b1;
            end
        end else if (sample_req) begin
            emit = 1'b1;
            if (!hdr_q) begin
                if (!fifo_empty) begin
                    fifo_pop = 1'b1;
                    flags_n  = pkt_flags_t'(fifo_rdata);
                    hdr_n    = 1'b1;
                    pend_n   = 1'b1;
                    emit     = 1'b0;
                end
            end else if (!idx_q[0]) begin
                if (!fifo_empty) begin
                    fifo_pop = 1'b1;
                    use_dec  = 1'b1;
                    byte_n   = fifo_rdata;
                    adv      = 1'b1;
                end
            end else begin
                use_dec = 1'b1;
                adv     = 1'b1;
            end
        end
        if (adv) begin
            if (idx_q == IDX_LAST) begin
                idx_n = '0;
                hdr_n = 1'b0;
            end else begin
                idx_n = idx_q + 1'b1;
            end
        end
    end

    // Output byte selection: decoded code, pass-through byte or silence.
    always_comb begin
        if (use_dec)                        out_n = code;
        else if (!packed_mode && !fifo_empty) out_n = fifo_rdata;
        else                                out_n = SILENCE;
    end

    // Sequencer state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hdr_q   <= 1'b0;
            pend_q  <= 1'b0;
            idx_q   <= '0;
            flags_q <= '0;
            byte_q  <= '0;
        end else begin
            hdr_q   <= hdr_n;
            pend_q  <= pend_n;
            idx_q   <= idx_n;
            flags_q <= flags_n;
            byte_q  <= byte_n;
        end
    end

    // Prediction history, advanced once per decoded sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist1 <= '0;
            hist2 <= '0;
        end else if (use_dec) begin
            hist2 <= hist1;
            hist1 <= sat_val;
        end
    end

    // Output register and valid pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            sample_out <= SILENCE;
        end else begin
            out_valid <= emit;
            if (emit) sample_out <= out_n;
        end
    end

    assign hdr_valid = hdr_q;
    assign pend      = pend_q;
    assign idx       = idx_q;
endmodule

// File: rtl/adpcm_blk_decoder.sv
// Module: top of the block-compressed ADPCM decoder. Wires the sequencer, the
// coefficient register file and the predictor together.
// Assumes an external show-ahead FIFO and a one-cycle sample strobe.
module adpcm_blk_decoder
    import adpcm_dec_pkg::*;
#(
    parameter int NUM_FILT    = 16,
    parameter int PKT_SAMPLES = 28
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  mode_ctrl,
    input  logic        coef_we,
    input  logic [4:0]  coef_addr,
    input  logic [7:0]  coef_wdata,
    input  logic        fifo_flush,
    input  logic        fifo_empty,
    input  logic [7:0]  fifo_rdata,
    output logic        fifo_pop,
    input  logic        sample_req,
    output logic        out_valid,
    output logic [7:0]  sample_out
);
    localparam int FILT_W = $clog2(NUM_FILT);
    localparam int COEF_AW = FILT_W + 1;
    localparam int IDX_W  = $clog2(PKT_SAMPLES);

    logic [3:0]               nib_w, shamt_w;
    logic [FILT_W-1:0]        filt_w;
    logic signed [7:0]        tap0_w, tap1_w;
    logic signed [SAMP_W-1:0] hist1_w, hist2_w, sat_w;
    logic [BYTE_W-1:0]        code_w;
    logic                     hdr_valid_w, pend_w;
    logic [IDX_W-1:0]         idx_w;

    adpcm_seq #(
        .PKT_SAMPLES(PKT_SAMPLES),
        .FILT_W     (FILT_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_ctrl  (mode_ctrl),
        .sample_req (sample_req),
        .fifo_flush (fifo_flush),
        .fifo_empty (fifo_empty),
        .fifo_rdata (fifo_rdata),
        .fifo_pop   (fifo_pop),
        .nib        (nib_w),
        .shamt      (shamt_w),
        .filt_sel   (filt_w),
        .hist1      (hist1_w),
        .hist2      (hist2_w),
        .sat_val    (sat_w),
        .code       (code_w),
        .out_valid  (out_valid),
        .sample_out (sample_out),
        .hdr_valid  (hdr_valid_w),
        .pend       (pend_w),
        .idx        (idx_w)
    );

    adpcm_coef_rf #(
        .NUM_FILT(NUM_FILT)
    ) u_coef (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (coef_we),
        .waddr (coef_addr[COEF_AW-1:0]),
        .wdata (coef_wdata),
        .sel   (filt_w),
        .tap0  (tap0_w),
        .tap1  (tap1_w)
    );

    adpcm_predictor u_pred (
        .nib     (nib_w),
        .shamt   (shamt_w),
        .tap0    (tap0_w),
        .tap1    (tap1_w),
        .hist1   (hist1_w),
        .hist2   (hist2_w),
        .sat_val (sat_w),
        .code    (code_w)
    );
endmodule

// File: rtl/adpcm_dec_checker.sv
// Module: protocol checker for the ADPCM decoder, bound to the top module.
module adpcm_dec_checker #(
    parameter int IDX_W    = 5,
    parameter int IDX_LAST = 27
) (
    input logic             clk,
    input logic             rst_n,
    input logic [7:0]       mode_ctrl,
    input logic             sample_req,
    input logic             fifo_flush,
    input logic             fifo_empty,
    input logic [7:0]       fifo_rdata,
    input logic             fifo_pop,
    input logic             out_valid,
    input logic [7:0]       sample_out,
    input logic             hdr_valid,
    input logic             pend,
    input logic [IDX_W-1:0] idx
);
    logic raw_sel;
    assign raw_sel = ((mode_ctrl & 8'h83) != 8'h82);

    // R10: a pop never consumes from an empty FIFO.
    p_pop_has_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> !fifo_empty);

    // R2: pass-through copies the head byte one cycle later.
    p_raw_copy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_sel && sample_req && !fifo_empty && !fifo_flush)
        |=> (out_valid && sample_out == $past(fifo_rdata)));

    // R2: pass-through underrun yields silence.
    p_raw_silence_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_sel && sample_req && fifo_empty && !fifo_flush)
        |=> (out_valid && sample_out == 8'h80));

    // R12: every result traces back to a strobe or a pending header fetch.
    p_valid_has_cause_r12: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($past(sample_req) || $past(pend)));

    // R3: a header fetch is pending for one cycle only.
    p_pend_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pend |=> !pend);

    // R11: a flush restarts at the packet boundary.
    p_flush_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_flush |=> (!hdr_valid && !pend && idx == '0));

    // R9: the sample index never exceeds the packet length.
    p_idx_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        idx <= IDX_W'(IDX_LAST));

    // R9: a packet closes only after its last sample or by a flush.
    p_close_at_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(hdr_valid) && !$past(fifo_flush)) |-> ($past(idx) == IDX_W'(IDX_LAST)));
endmodule

bind adpcm_blk_decoder adpcm_dec_checker #(
    .IDX_W   (IDX_W),
    .IDX_LAST(PKT_SAMPLES - 1)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_ctrl  (mode_ctrl),
    .sample_req (sample_req),
    .fifo_flush (fifo_flush),
    .fifo_empty (fifo_empty),
    .fifo_rdata (fifo_rdata),
    .fifo_pop   (fifo_pop),
    .out_valid  (out_valid),
    .sample_out (sample_out),
    .hdr_valid  (hdr_valid_w),
    .pend       (pend_w),
    .idx        (idx_w)
);

// File: tb/adpcm_blk_decoder_test.sv
// Directed bench: a FIFO model, a requirement-level reference model, one task per scenario.
module adpcm_blk_decoder_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] mode_ctrl = 8'h80;
    logic       coef_we = 1'b0;
    logic [4:0] coef_addr = '0;
    logic [7:0] coef_wdata = '0;
    logic       fifo_flush = 1'b0;
    logic       fifo_empty;
    logic [7:0] fifo_rdata;
    logic       fifo_pop;
    logic       sample_req = 1'b0;
    logic       out_valid;
    logic [7:0] sample_out;

    int n_chk = 0, n_bad = 0;

    // FIFO model: show-ahead, bench pushes, design pops.
    logic [7:0] fmem [0:1023];
    int wr_p = 0, rd_p = 0;
    assign fifo_empty = (rd_p == wr_p);
    assign fifo_rdata = fmem[rd_p[9:0]];
    always @(posedge clk) if (fifo_pop) rd_p <= rd_p + 1;

    // Reference model state.
    logic [7:0] m_coef [0:31];
    int m_p1 = 0, m_p2 = 0, m_shift = 0, m_filt = 0, m_idx = 0, m_rd = 0;
    bit m_hdr = 0;
    logic [7:0] m_byte = 8'h00;

    always #4 clk = ~clk;

    adpcm_blk_decoder uut (
        .clk(clk), .rst_n(rst_n), .mode_ctrl(mode_ctrl),
        .coef_we(coef_we), .coef_addr(coef_addr), .coef_wdata(coef_wdata),
        .fifo_flush(fifo_flush), .fifo_empty(fifo_empty), .fifo_rdata(fifo_rdata),
        .fifo_pop(fifo_pop), .sample_req(sample_req),
        .out_valid(out_valid), .sample_out(sample_out)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] b);
        fmem[wr_p[9:0]] = b;
        wr_p++;
    endtask

    task automatic set_coef(input int a, input logic [7:0] v);
        @(negedge clk);
        coef_we = 1'b1; coef_addr = 5'(a); coef_wdata = v;
        @(negedge clk);
        coef_we = 1'b0;
        m_coef[a] = v;
    endtask

    task automatic do_flush();
        @(negedge clk);
        fifo_flush = 1'b1;
        @(negedge clk);
        fifo_flush = 1'b0;
        wr_p = rd_p; m_rd = rd_p;
        m_hdr = 0; m_idx = 0;
    endtask

    // Model of one compressed sample from a nibble (R5, R6, R7, R8).
    task automatic mdec(input logic [3:0] nb, output logic [7:0] res);
        int d, f0, f1, pr, t, q;
        d  = $signed({nb, 12'h000});
        d  = d >>> m_shift;
        f0 = $signed(m_coef[2*m_filt+1]);
        f1 = $signed(m_coef[2*m_filt]);
        pr = (m_p1*f0 + m_p2*f1 + 32) >>> 6;
        t  = d + pr;
        if (t > 32767) t = 32767;
        if (t < -32768) t = -32768;
        q  = t / 256;
        res = 8'(q) ^ 8'h80;
        m_p2 = m_p1; m_p1 = t;
    endtask

    // One strobe: predict value and latency, then compare output, latency and FIFO position.
    task automatic step(input string tag);
        logic [7:0] ev;
        int el, lat;
        bit avail;
        ev = 8'h80; el = 1;
        avail = (m_rd < wr_p);
        if ((mode_ctrl & 8'h83) != 8'h82) begin
            if (avail) begin ev = fmem[m_rd[9:0]]; m_rd++; end
        end else if (!m_hdr) begin
            if (avail) begin
                m_shift = fmem[m_rd[9:0]] & 8'h0F;
                m_filt  = fmem[m_rd[9:0]] >> 4;
                m_rd++; m_hdr = 1; el = 2;
                if (m_rd < wr_p) begin
                    m_byte = fmem[m_rd[9:0]]; m_rd++;
                    mdec(m_byte[3:0], ev); m_idx = 1;
                end
            end
        end else if (m_idx % 2 == 0) begin
            if (avail) begin
                m_byte = fmem[m_rd[9:0]]; m_rd++;
                mdec(m_byte[3:0], ev); m_idx++;
            end
        end else begin
            mdec(m_byte[7:4], ev); m_idx++;
        end
        if (m_idx == 28) begin m_idx = 0; m_hdr = 0; end
        @(negedge clk);
        sample_req = 1'b1;
        @(negedge clk);
        sample_req = 1'b0;
        lat = 1;
        while (!out_valid && lat < 4) begin @(negedge clk); lat++; end
        check(out_valid && sample_out == ev, {tag, " value"}, int'(sample_out), int'(ev));
        check(lat == el, {tag, " latency"}, lat, el);
        check(rd_p == m_rd, {tag, " fifo position"}, rd_p, m_rd);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(!out_valid && !fifo_pop && sample_out == 8'h80, "R12 reset state",
              {out_valid, fifo_pop, sample_out}, 32'h080);
    endtask

    task automatic t_raw();
        mode_ctrl = 8'h80;
        push(8'h12); push(8'hAB); push(8'h00);
        step("R2 raw byte0"); step("R2 raw byte1"); step("R2 raw byte2");
        step("R2 raw empty silence");
        mode_ctrl = 8'h03; push(8'h5A); step("R1 ctrl 0x03 raw");
        mode_ctrl = 8'h83; push(8'hC3); step("R1 ctrl 0x83 raw");
        step("R1 R2 raw empty");
    endtask

    task automatic t_plain_packet();
        mode_ctrl = 8'hFE;
        push(8'h00);
        for (int i = 0; i < 14; i++) push(8'((i * 37 + 5) & 8'hFF));
        for (int i = 0; i < 28; i++) step($sformatf("R1 R3 R4 plain sample %0d", i));
        check(!m_hdr, "R9 packet closed", m_hdr, 0);
    endtask

    task automatic t_filtered();
        mode_ctrl = 8'h82;
        set_coef(6, 8'hEC);
        set_coef(7, 8'd100);
        push(8'h32);
        for (int i = 0; i < 14; i++) push(8'((i * 53 + 17) & 8'hFF));
        for (int i = 0; i < 28; i++) step($sformatf("R5 R8 R9 filtered sample %0d", i));
    endtask

    task automatic t_saturate();
        set_coef(2, 8'd127);
        set_coef(3, 8'd127);
        push(8'h10);
        for (int i = 0; i < 7; i++) push(8'h77);
        for (int i = 0; i < 7; i++) push(8'h88);
        for (int i = 0; i < 28; i++) step($sformatf("R6 saturate sample %0d", i));
    endtask

    task automatic t_truncate();
        do_flush();
        push(8'h04); push(8'hFF); push(8'h1F);
        step("R7 minus256 to 0x7F"); step("R7 high F");
        step("R7 low F"); step("R7 plus256 to 0x81");
        do_flush();
        push(8'h05); push(8'hEF);
        step("R7 minus128 to 0x80"); step("R7 high E");
    endtask

    task automatic t_underrun();
        do_flush();
        push(8'h00);
        step("R10 flags only silence");
        step("R10 retry data byte silence");
        push(8'h35);
        step("R10 resume low nibble");
        step("R4 high nibble no pop");
        step("R10 empty mid packet");
        push(8'h9C);
        step("R10 resume after underrun");
    endtask

    task automatic t_flush();
        do_flush();
        push(8'h32); push(8'h41); push(8'h7E);
        step("R11 before flush 0"); step("R11 before flush 1"); step("R11 before flush 2");
        do_flush();
        push(8'h00); push(8'h2D);
        step("R11 new flags after flush");
        step("R11 high nibble after flush");
    endtask

    initial begin
        for (int i = 0; i < 32; i++) m_coef[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_raw();
        t_plain_packet();
        t_filtered();
        t_saturate();
        t_truncate();
        t_underrun();
        t_flush();
        repeat (3) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule